// File: doc/BRIEF.md
# Range Protection Lookaside Buffer

This block is a small, fully associative protection cache that sits next to the CPU. It checks each memory reference against protection triples held in its slots. Each slot binds an accessing protection-domain address to a region and to a set of rights. A region is not a page. It is described by a match pattern and a don't-care pattern, so one slot can cover a region of any power-of-two-aligned size. Because any subset of bits may be don't-care, that region may also be non-contiguous.

Miss-handling software loads slots through a fill port. A fill with the same domain and mask pair as a valid slot rewrites that slot. Otherwise the fill takes the lowest free slot, and when no slot is free it takes the slot named by a round-robin pointer. The lookup port carries the current domain, the reference address and the access type. The verdict appears one cycle later as hit, allow, fault or miss.

A slot may carry the switch right and a new-domain name. If such a slot matches a reference that it does not otherwise grant, the block loads the new name into its general protection-domain base register. It then re-checks the same reference against that new domain, which costs one extra cycle. The machine has two named states. In `ST_IDLE`, requests are accepted. The transition `ST_IDLE -> ST_SWITCH` is taken on a switch-eligible match. In `ST_SWITCH`, the retry runs and requests are ignored. The transition `ST_SWITCH -> ST_IDLE` is always taken after one cycle.

Top module: `rgn_prot_buf`

## Requirements
- R1: After reset, `resp_valid`, `busy` and `gpd_base` are all zero, and every slot is empty, so a first lookup reports a miss.
- R2: An address lies in a slot's region when `((addr ^ match) & ~dc) == 0`. For example, match 0x0C80 with don't-care 0x017F covers 0x0C80–0x0CFF and 0x0D80–0x0DFF, and excludes 0x0D00 and 0x0C7F.
- R3: A slot matches only when its stored domain equals the lookup domain exactly. The same address under another domain misses.
- R4: A request accepted at one clock edge sets `resp_valid` for exactly one cycle after that edge, with exactly one of allow, fault or miss set. Rights bits are read=bit 0, write=bit 1, execute=bit 2, switch=bit 3. `req_acc` code 0 requests read, 1 write, 2 execute, and 3 is never granted. Allow is set when the matching slot holds the requested bit.
- R5: A matching slot that lacks the requested right and lacks the switch bit gives fault with `resp_hit`=1. When no slot matches, the result is miss with `resp_hit`=0.
- R6: A fill whose domain, match and don't-care all equal those of a valid slot rewrites that slot's rights and new-domain fields. Otherwise the fill goes to the lowest-index empty slot.
- R7: When every slot is valid and no slot shares the fill key, the fill replaces the slot at the round-robin pointer. The pointer starts at 0 and advances by one, wrapping, on each such replacement.
- R8: `inv_all` empties every slot in one cycle. A fill presented in the same cycle is dropped.
- R9: If several slots match, the lowest-index slot alone decides the result.
- R10: A matching slot with the switch bit that does not grant the requested right loads its new-domain name into `gpd_base` and raises `busy` for one cycle. The same address and access are then re-checked under the new domain. The result appears two cycles after the request, with `resp_switched`=1.
- R11: A request presented while `busy` is high is ignored and produces no response.
- R12: The retry never switches again. A retry match that lacks the requested right gives fault even when the slot holds the switch bit, and `gpd_base` keeps the first new domain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_all | input | 1 | Empty every slot |
| fill_valid | input | 1 | Load a triple this cycle |
| fill_dom | input | VA_W | Accessing domain of the triple |
| fill_match | input | VA_W | Region match pattern |
| fill_dc | input | VA_W | Region don't-care pattern (1 = ignore bit) |
| fill_rights | input | 4 | Rights: bit0 read, bit1 write, bit2 execute, bit3 switch |
| fill_newdom | input | VA_W | Domain entered through a switch |
| req_valid | input | 1 | Reference to check |
| req_dom | input | VA_W | Current domain register |
| req_addr | input | VA_W | Reference address |
| req_acc | input | 2 | Access code: 0 read, 1 write, 2 execute, 3 none |
| busy | output | 1 | Domain switch in progress; requests ignored |
| resp_valid | output | 1 | Verdict valid |
| resp_hit | output | 1 | A slot matched domain and region |
| resp_allow | output | 1 | Access granted |
| resp_fault | output | 1 | Matched but the right is missing |
| resp_miss | output | 1 | No slot matched |
| resp_switched | output | 1 | Verdict came from a post-switch retry |
| gpd_base | output | VA_W | General protection-domain base register |

## Verification
The mask match is tried with addresses inside both halves of a split region, in the gap between the halves, and just below the region. This separates a correct don't-care mask from a plain range or prefix compare. Lookups on the same address under a different domain, and with each access code, separate the domain check from the rights check. Overlapping slots with different rights tell lowest-index priority apart from any other order. A fill sequence that rewrites one slot before the buffer overflows tells a rewrite apart from an eviction, and shows where the round-robin pointer stands. Switch tests end in allow, in miss, and in a slot holding only the switch bit. These cover the base-register update, the ignored requests while busy, and the absence of a second switch.

// File: rtl/rpb_pkg.sv
package rpb_pkg;
    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_SWITCH = 1'b1
    } rpb_state_e;

    localparam int RT_READ   = 0;
    localparam int RT_WRITE  = 1;
    localparam int RT_EXEC   = 2;
    localparam int RT_SWITCH = 3;

    // Access code 3 requests nothing that a slot can grant.
    function automatic logic acc_granted(input logic [3:0] rights, input logic [1:0] acc);
        return (acc == 2'd3) ? 1'b0 : rights[acc];
    endfunction
endpackage

// File: rtl/rpb_entry_cmp.sv
module rpb_entry_cmp #(
    parameter int VA_W = 64
) (
    input  logic            vld,
    input  logic [VA_W-1:0] e_dom,
    input  logic [VA_W-1:0] e_match,
    input  logic [VA_W-1:0] e_dc,
    input  logic [VA_W-1:0] k_dom,
    input  logic [VA_W-1:0] k_addr,
    input  logic [VA_W-1:0] f_dom,
    input  logic [VA_W-1:0] f_match,
    input  logic [VA_W-1:0] f_dc,
    output logic            look_hit,
    output logic            key_same
);
    always_comb begin
        look_hit = vld && (e_dom == k_dom) && (((k_addr ^ e_match) & ~e_dc) == '0);
        key_same = vld && (e_dom == f_dom) && (e_match == f_match) && (e_dc == f_dc);
    end
endmodule

// File: rtl/rpb_first.sv
module rpb_first #(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rgn_prot_buf.sv
module rgn_prot_buf
    import rpb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    parameter int VA_W        = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inv_all,
    input  logic            fill_valid,
    input  logic [VA_W-1:0] fill_dom,
    input  logic [VA_W-1:0] fill_match,
    input  logic [VA_W-1:0] fill_dc,
    input  logic [3:0]      fill_rights,
    input  logic [VA_W-1:0] fill_newdom,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_dom,
    input  logic [VA_W-1:0] req_addr,
    input  logic [1:0]      req_acc,
    output logic            busy,
    output logic            resp_valid,
    output logic            resp_hit,
    output logic            resp_allow,
    output logic            resp_fault,
    output logic            resp_miss,
    output logic            resp_switched,
    output logic [VA_W-1:0] gpd_base
);
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_ENTRIES - 1);

    // Slot storage
    logic [NUM_ENTRIES-1:0] ent_vld;
    logic [VA_W-1:0]        ent_dom    [NUM_ENTRIES];
    logic [VA_W-1:0]        ent_match  [NUM_ENTRIES];
    logic [VA_W-1:0]        ent_dc     [NUM_ENTRIES];
    logic [VA_W-1:0]        ent_newdom [NUM_ENTRIES];
    logic [3:0]             ent_rights [NUM_ENTRIES];
    logic [IDX_W-1:0]       rr_ptr;

    rpb_state_e      state, state_n;
    logic [VA_W-1:0] hold_addr;
    logic [1:0]      hold_acc;

    // Lookup key: live request in ST_IDLE, held reference under new domain in ST_SWITCH
    logic [VA_W-1:0] look_dom, look_addr;
    logic [1:0]      look_acc;
    logic            look_go;

    always_comb begin
        if (state == ST_SWITCH) begin
            look_dom  = gpd_base;
            look_addr = hold_addr;
            look_acc  = hold_acc;
        end else begin
            look_dom  = req_dom;
            look_addr = req_addr;
            look_acc  = req_acc;
        end
        look_go = (state == ST_SWITCH) || req_valid;
    end

    logic [NUM_ENTRIES-1:0] look_hits, same_hits;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        rpb_entry_cmp #(.VA_W(VA_W)) u_cmp (
            .vld      (ent_vld[g]),
            .e_dom    (ent_dom[g]),
            .e_match  (ent_match[g]),
            .e_dc     (ent_dc[g]),
            .k_dom    (look_dom),
            .k_addr   (look_addr),
            .f_dom    (fill_dom),
            .f_match  (fill_match),
            .f_dc     (fill_dc),
            .look_hit (look_hits[g]),
            .key_same (same_hits[g])
        );
    end

    logic             look_found, same_found, free_found;
    logic [IDX_W-1:0] look_idx, same_idx, free_idx;

    rpb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_look (
        .vec(look_hits), .found(look_found), .idx(look_idx));
    rpb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_same (
        .vec(same_hits), .found(same_found), .idx(same_idx));
    rpb_first #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_free (
        .vec(~ent_vld), .found(free_found), .idx(free_idx));

    logic [3:0] sel_rights;
    logic       granted, go_switch;

    always_comb begin
        sel_rights = ent_rights[look_idx];
        granted    = look_found && acc_granted(sel_rights, look_acc);
        go_switch  = (state == ST_IDLE) && req_valid && look_found
                     && !granted && sel_rights[RT_SWITCH];
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (go_switch) state_n = ST_SWITCH;
            ST_SWITCH: state_n = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    assign busy = (state == ST_SWITCH);

    // Outputs, base register and held reference
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid    <= 1'b0;
            resp_hit      <= 1'b0;
            resp_allow    <= 1'b0;
            resp_fault    <= 1'b0;
            resp_miss     <= 1'b0;
            resp_switched <= 1'b0;
            gpd_base      <= '0;
            hold_addr     <= '0;
            hold_acc      <= '0;
        end else begin
            if (look_go && !go_switch) begin
                resp_valid    <= 1'b1;
                resp_hit      <= look_found;
                resp_allow    <= granted;
                resp_fault    <= look_found && !granted;
                resp_miss     <= !look_found;
                resp_switched <= (state == ST_SWITCH);
            end else begin
                resp_valid    <= 1'b0;
                resp_hit      <= 1'b0;
                resp_allow    <= 1'b0;
                resp_fault    <= 1'b0;
                resp_miss     <= 1'b0;
                resp_switched <= 1'b0;
            end
            if (go_switch) begin
                gpd_base  <= ent_newdom[look_idx];
                hold_addr <= req_addr;
                hold_acc  <= req_acc;
            end
        end
    end

    // Fill and replacement
    logic [IDX_W-1:0] fill_idx;
    logic             use_rr;

    always_comb begin
        use_rr   = !same_found && !free_found;
        fill_idx = same_found ? same_idx : (free_found ? free_idx : rr_ptr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_vld <= '0;
            rr_ptr  <= '0;
        end else if (inv_all) begin
            ent_vld <= '0;
        end else if (fill_valid) begin
            ent_vld[fill_idx] <= 1'b1;
            if (use_rr) rr_ptr <= (rr_ptr == LAST_IDX) ? '0 : rr_ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (fill_valid && !inv_all) begin
            ent_dom[fill_idx]    <= fill_dom;
            ent_match[fill_idx]  <= fill_match;
            ent_dc[fill_idx]     <= fill_dc;
            ent_rights[fill_idx] <= fill_rights;
            ent_newdom[fill_idx] <= fill_newdom;
        end
    end
endmodule

// File: rtl/rgn_prot_buf_chk.sv
module rgn_prot_buf_chk #(
    parameter int VA_W = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            inv_all,
    input logic            req_valid,
    input logic            busy,
    input logic            resp_valid,
    input logic            resp_hit,
    input logic            resp_allow,
    input logic            resp_fault,
    input logic            resp_miss,
    input logic            resp_switched,
    input logic [VA_W-1:0] gpd_base
);
    assert_one_verdict_R4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> ($countones({resp_allow, resp_fault, resp_miss}) == 1));

    assert_hit_consistent_R5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_hit == !resp_miss));

    assert_switch_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_retry_responds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (resp_valid && resp_switched));

    assert_base_moves_on_switch_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) || $stable(gpd_base));

    assert_busy_no_verdict_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !resp_valid);

    assert_inv_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_all ##1 (req_valid && !busy)) |=> (resp_valid && resp_miss));
endmodule

bind rgn_prot_buf rgn_prot_buf_chk #(.VA_W(VA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .inv_all       (inv_all),
    .req_valid     (req_valid),
    .busy          (busy),
    .resp_valid    (resp_valid),
    .resp_hit      (resp_hit),
    .resp_allow    (resp_allow),
    .resp_fault    (resp_fault),
    .resp_miss     (resp_miss),
    .resp_switched (resp_switched),
    .gpd_base      (gpd_base)
);

// File: tb/rgn_prot_buf_bench.sv
module rgn_prot_buf_bench;
    localparam int CLK_PERIOD = 10;
    localparam int VA_W = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            inv_all = 1'b0;
    logic            fill_valid = 1'b0;
    logic [VA_W-1:0] fill_dom = '0, fill_match = '0, fill_dc = '0, fill_newdom = '0;
    logic [3:0]      fill_rights = '0;
    logic            req_valid = 1'b0;
    logic [VA_W-1:0] req_dom = '0, req_addr = '0;
    logic [1:0]      req_acc = '0;
    logic            busy, resp_valid, resp_hit, resp_allow, resp_fault, resp_miss, resp_switched;
    logic [VA_W-1:0] gpd_base;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rgn_prot_buf #(.NUM_ENTRIES(8), .VA_W(VA_W)) u_rgn_prot_buf (.*);

    task automatic chk(input string tag, input logic [VA_W-1:0] act, input logic [VA_W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [VA_W-1:0] dom, input logic [VA_W-1:0] m,
                        input logic [VA_W-1:0] dc, input logic [3:0] rt,
                        input logic [VA_W-1:0] nd);
        @(negedge clk);
        fill_valid = 1'b1; fill_dom = dom; fill_match = m; fill_dc = dc;
        fill_rights = rt; fill_newdom = nd;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic invalidate();
        @(negedge clk);
        inv_all = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
    endtask

    // Verdict code: 1 allow, 2 fault, 3 miss; hit and switched reported apart
    task automatic look(input logic [VA_W-1:0] dom, input logic [VA_W-1:0] addr,
                        input logic [1:0] acc, output int verdict, output logic hit,
                        output logic sw);
        @(negedge clk);
        req_valid = 1'b1; req_dom = dom; req_addr = addr; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        if (busy) @(negedge clk);
        verdict = !resp_valid ? 0 : resp_allow ? 1 : resp_fault ? 2 : resp_miss ? 3 : 0;
        hit = resp_hit;
        sw  = resp_switched;
    endtask

    task automatic t_reset();
        int v; logic h, s;
        chk("R1 resp_valid", VA_W'(resp_valid), 0);
        chk("R1 busy", VA_W'(busy), 0);
        chk("R1 gpd_base", gpd_base, 0);
        look(64'h7, 64'h0C80, 2'd0, v, h, s);
        chk("R1 empty lookup miss", VA_W'(v), 3);
    endtask

    task automatic t_region();
        int v; logic h, s;
        fill(64'h7, 64'h0C80, 64'h017F, 4'b0001, 64'h0);
        look(64'h7, 64'h0C80, 2'd0, v, h, s); chk("R2 0C80 allow", VA_W'(v), 1);
        look(64'h7, 64'h0CFF, 2'd0, v, h, s); chk("R2 0CFF allow", VA_W'(v), 1);
        look(64'h7, 64'h0D80, 2'd0, v, h, s); chk("R2 0D80 allow", VA_W'(v), 1);
        look(64'h7, 64'h0DFF, 2'd0, v, h, s); chk("R2 0DFF allow", VA_W'(v), 1);
        look(64'h7, 64'h0D00, 2'd0, v, h, s); chk("R2 gap 0D00 miss", VA_W'(v), 3);
        look(64'h7, 64'h0C7F, 2'd0, v, h, s); chk("R2 below 0C7F miss", VA_W'(v), 3);
        look(64'h8, 64'h0C80, 2'd0, v, h, s); chk("R3 other domain miss", VA_W'(v), 3);
        look(64'h7, 64'h0C90, 2'd1, v, h, s);
        chk("R5 write fault", VA_W'(v), 2); chk("R5 fault hit", VA_W'(h), 1);
        look(64'h7, 64'h0C90, 2'd3, v, h, s); chk("R4 code3 never granted", VA_W'(v), 2);
        look(64'h7, 64'h0E80, 2'd0, v, h, s); chk("R5 miss hit low", VA_W'(h), 0);
    endtask

    task automatic t_replace();
        int v; logic h, s;
        invalidate();
        for (int i = 1; i <= 8; i++) fill(64'h1, VA_W'(i) << 8, 64'hFF, 4'b0001, 64'h0);
        fill(64'h1, 64'h400, 64'hFF, 4'b0011, 64'h0);
        look(64'h1, 64'h405, 2'd1, v, h, s); chk("R6 rewrite rights", VA_W'(v), 1);
        fill(64'h1, 64'h900, 64'hFF, 4'b0001, 64'h0);
        look(64'h1, 64'h105, 2'd0, v, h, s); chk("R7 slot0 evicted", VA_W'(v), 3);
        look(64'h1, 64'h205, 2'd0, v, h, s); chk("R6 slot1 kept", VA_W'(v), 1);
        look(64'h1, 64'h905, 2'd0, v, h, s); chk("R7 new entry", VA_W'(v), 1);
        fill(64'h1, 64'hA00, 64'hFF, 4'b0001, 64'h0);
        look(64'h1, 64'h205, 2'd0, v, h, s); chk("R7 slot1 evicted next", VA_W'(v), 3);
        look(64'h1, 64'h305, 2'd0, v, h, s); chk("R7 slot2 kept", VA_W'(v), 1);
    endtask

    task automatic t_invalidate();
        int v; logic h, s;
        @(negedge clk);
        inv_all = 1'b1; fill_valid = 1'b1; fill_dom = 64'h1; fill_match = 64'hB00;
        fill_dc = 64'hFF; fill_rights = 4'b0001; fill_newdom = '0;
        @(negedge clk);
        inv_all = 1'b0; fill_valid = 1'b0;
        look(64'h1, 64'h305, 2'd0, v, h, s); chk("R8 cleared", VA_W'(v), 3);
        look(64'h1, 64'hB05, 2'd0, v, h, s); chk("R8 fill dropped", VA_W'(v), 3);
    endtask

    task automatic t_priority();
        int v; logic h, s;
        invalidate();
        fill(64'h5, 64'h100, 64'hFF, 4'b0001, 64'h0);
        fill(64'h5, 64'h000, 64'h1FF, 4'b0011, 64'h0);
        look(64'h5, 64'h120, 2'd1, v, h, s); chk("R9 lowest slot wins", VA_W'(v), 2);
        look(64'h5, 64'h020, 2'd1, v, h, s); chk("R9 single match", VA_W'(v), 1);
    endtask

    task automatic t_switch();
        int v; logic h, s;
        invalidate();
        fill(64'h10, 64'h4000, 64'h0, 4'b1000, 64'h20);
        fill(64'h20, 64'h4000, 64'h0, 4'b0100, 64'h0);
        @(negedge clk);
        req_valid = 1'b1; req_dom = 64'h10; req_addr = 64'h4000; req_acc = 2'd2;
        @(negedge clk);
        chk("R10 busy", VA_W'(busy), 1);
        chk("R10 no early verdict", VA_W'(resp_valid), 0);
        chk("R10 base loaded", gpd_base, 64'h20);
        req_addr = 64'h9999;
        @(negedge clk);
        chk("R10 retry verdict", VA_W'(resp_valid && resp_allow), 1);
        chk("R10 switched flag", VA_W'(resp_switched), 1);
        req_valid = 1'b0;
        @(negedge clk);
        chk("R11 busy request ignored", VA_W'(resp_valid), 0);
        fill(64'h10, 64'h5000, 64'h0, 4'b1000, 64'h30);
        look(64'h10, 64'h5000, 2'd0, v, h, s);
        chk("R10 retry miss", VA_W'(v), 3); chk("R10 miss switched", VA_W'(s), 1);
        chk("R10 base new", gpd_base, 64'h30);
        fill(64'h30, 64'h6000, 64'h0, 4'b1000, 64'h40);
        fill(64'h10, 64'h6000, 64'h0, 4'b1000, 64'h30);
        look(64'h10, 64'h6000, 2'd0, v, h, s);
        chk("R12 no chained switch", VA_W'(v), 2);
        chk("R12 base kept", gpd_base, 64'h30);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_region();
        t_replace();
        t_invalidate();
        t_priority();
        t_switch();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule